// File: doc/BRIEF.md
# Receive Line Activity Qualifier

This block decides whether the receive line carries real traffic or only noise. Each cycle the analog comparator reports whether it saw a valid pulse, and for 10 Mb/s operation a separate flag reports whether Manchester-coded data is present. A speed input selects the 100 Mb/s or the 10 Mb/s rules. From these inputs the block keeps one qualified-activity flag. That flag drives three companion controls. The first lowers the comparator's detection level once traffic is accepted. The second releases the adaptive receive circuits from their quiescent condition. The third moves the clock-recovery loop's reference from the local transmit clock to the incoming data.

Qualification is hysteretic. At least `NEED_PULSES` valid pulses (two by default) must arrive, each within `TIMEOUT` cycles of the one before it, before the flag rises. A lone noise pulse ages out of that window and is discarded. Once the flag is high, the rule that ends it depends on speed. At 100 Mb/s it falls after `TIMEOUT` pulse-free cycles (150 cycles at 125 MHz, about 1.2 µs), and every valid pulse reloads that count. At 10 Mb/s it falls as soon as Manchester data is absent. Any change of the speed input drops the flag and discards all partial progress.

Top module: `line_qualifier`

## Requirements
- R1: While the flag is low, a valid pulse that brings the pending count to `NEED_PULSES` makes `qual_o` read 1 from the next clock edge on. Each pending pulse other than the first must arrive no more than `TIMEOUT` cycles after the previous one.
- R2: `thresh_low_o` equals `qual_o` on every cycle. The value 1 selects the lowered detection level and 0 selects the squelch level.
- R3: `adapt_run_o` equals `qual_o` on every cycle. The value 1 releases the adaptive circuits and 0 holds them quiescent.
- R4: When `speed_100` is 1 and the flag is high, each valid pulse restarts the idle count. After `TIMEOUT` consecutive cycles with no valid pulse, `qual_o` reads 0 from the following edge.
- R5: When `speed_100` is 0 and the flag is high, a cycle with `manch_present` at 0 makes `qual_o` read 0 after the next edge. Pulse gaps of any length have no effect on the flag in this mode.
- R6: `ref_rx_o` equals `qual_o` on every cycle. The value 1 selects the received data stream as the recovery reference and 0 selects the local transmit clock.
- R7: While `rst_n` is low, all four outputs are 0, whatever the other inputs do.
- R8: While the flag is low, a pending pulse is discarded when `TIMEOUT` cycles pass after it with no further pulse. A later pulse then starts a new count from one.
- R9: A cycle in which `speed_100` differs from its value in the previous cycle makes `qual_o` read 0 after the edge and clears the pending pulse count. The input is taken as 1 before the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock (125 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 = 100 Mb/s rules, 0 = 10 Mb/s rules |
| pulse_valid | input | 1 | Comparator saw a valid pulse this cycle |
| manch_present | input | 1 | Manchester data currently present (10 Mb/s only) |
| qual_o | output | 1 | Qualified receive activity |
| thresh_low_o | output | 1 | 1 = lowered detection level, 0 = squelch level |
| adapt_run_o | output | 1 | 1 = adaptive circuits released |
| ref_rx_o | output | 1 | 1 = recovery reference from received data, 0 = from transmit clock |

## Verification
The assertions check several properties on every cycle. The three companion outputs must track the flag. The flag may rise only in the cycle after a valid pulse. Loss of Manchester data at 10 Mb/s and any speed change must drop the flag on the next edge. At 100 Mb/s the timer's expiry must coincide exactly with an independent count of pulse-free cycles. Three behaviours are shown only by the bench's scenarios, because they span windows of `TIMEOUT` cycles: the exact boundary where a second pulse still qualifies, the ageing out of an isolated noise pulse, and the clearing of a partial count by a speed change.

// File: rtl/lq_pkg.sv
package lq_pkg;

  typedef enum logic {
    LQ_SQUELCH = 1'b0,
    LQ_PASS    = 1'b1
  } lq_state_e;

  // True when one more pulse on top of `held` reaches the required count.
  function automatic logic count_reaches(input int unsigned held,
                                         input int unsigned need);
    return (held + 1) >= need;
  endfunction

  // Idle/window timer step: reload, hold at zero, or count down.
  function automatic int unsigned timer_step(input int unsigned cur,
                                             input logic load,
                                             input logic run,
                                             input int unsigned reload);
    if (load)
      return reload;
    if (run && cur != 0)
      return cur - 1;
    return cur;
  endfunction

  // Expiry fires on the last non-reloaded cycle of a running window.
  function automatic logic timer_last(input int unsigned cur,
                                      input logic load,
                                      input logic run);
    return run && !load && (cur == 1);
  endfunction

endpackage

// File: rtl/lq_pulse_count.sv
module lq_pulse_count
  import lq_pkg::*;
#(
  parameter int unsigned NEED_PULSES = 2,
  localparam int unsigned CW = $clog2(NEED_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count_o,
  output logic          pending_o,
  output logic          qualify_o
);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else if (clr)
      count_q <= '0;
    else if (inc)
      count_q <= count_q + CW'(1);
  end

  assign count_o   = count_q;
  assign pending_o = (count_q != '0);
  assign qualify_o = inc && count_reaches(int'(count_q), NEED_PULSES);

endmodule

// File: rtl/lq_idle_timer.sv
module lq_idle_timer
  import lq_pkg::*;
#(
  parameter int unsigned TIMEOUT = 150,
  localparam int unsigned TW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          run,
  output logic [TW-1:0] value_o,
  output logic          expire_o
);

  logic [TW-1:0] value_q;
  logic [TW-1:0] value_d;

  always_comb begin
    value_d = TW'(timer_step(int'(value_q), load, run, TIMEOUT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      value_q <= '0;
    else if (clr)
      value_q <= '0;
    else
      value_q <= value_d;
  end

  assign value_o  = value_q;
  assign expire_o = timer_last(int'(value_q), load, run);

endmodule

// File: rtl/line_qualifier.sv
module line_qualifier
  import lq_pkg::*;
#(
  parameter int unsigned NEED_PULSES = 2,
  parameter int unsigned TIMEOUT     = 150,
  localparam int unsigned CW = $clog2(NEED_PULSES + 1),
  localparam int unsigned TW = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_100,
  input  logic pulse_valid,
  input  logic manch_present,
  output logic qual_o,
  output logic thresh_low_o,
  output logic adapt_run_o,
  output logic ref_rx_o
);

  lq_state_e state_q, state_d;
  logic      speed_q;

  // Named internal events, also observed by the bound checker.
  logic in_pass;
  logic speed_chg;
  logic qual_hit;
  logic win_expire;
  logic idle_drop;
  logic manch_drop;
  logic drop;
  logic tmr_expire;

  logic          cnt_clr, cnt_inc, cnt_pending;
  logic [CW-1:0] cnt_value;
  logic          tmr_clr, tmr_load, tmr_run;
  logic [TW-1:0] tmr_value;

  assign in_pass   = (state_q == LQ_PASS);
  assign speed_chg = speed_100 ^ speed_q;

  // Pulse accumulation happens only while squelched.
  assign cnt_inc = !in_pass && pulse_valid && !speed_chg;
  assign cnt_clr = speed_chg || in_pass || qual_hit || win_expire;

  // One timer serves both the qualification window and the idle timeout.
  assign tmr_load = pulse_valid && !speed_chg && (!in_pass || speed_100);
  assign tmr_run  = in_pass ? speed_100 : cnt_pending;

  assign win_expire = !in_pass && !speed_chg && tmr_expire;
  assign idle_drop  = in_pass && !speed_chg && speed_100 && tmr_expire;
  assign manch_drop = in_pass && !speed_chg && !speed_100 && !manch_present;
  assign drop       = idle_drop || manch_drop;

  assign tmr_clr = speed_chg || drop || win_expire;

  lq_pulse_count #(
    .NEED_PULSES(NEED_PULSES)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .inc       (cnt_inc),
    .count_o   (cnt_value),
    .pending_o (cnt_pending),
    .qualify_o (qual_hit)
  );

  lq_idle_timer #(
    .TIMEOUT(TIMEOUT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .load     (tmr_load),
    .run      (tmr_run),
    .value_o  (tmr_value),
    .expire_o (tmr_expire)
  );

  always_comb begin
    state_d = state_q;
    if (speed_chg)
      state_d = LQ_SQUELCH;
    else if (!in_pass && qual_hit)
      state_d = LQ_PASS;
    else if (drop)
      state_d = LQ_SQUELCH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LQ_SQUELCH;
      speed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      speed_q <= speed_100;
    end
  end

  assign qual_o       = in_pass;
  assign thresh_low_o = in_pass;
  assign adapt_run_o  = in_pass;
  assign ref_rx_o     = in_pass;

  logic unused_ok;
  assign unused_ok = ^{cnt_value, tmr_value};

endmodule

// File: rtl/line_qualifier_checker.sv
module line_qualifier_checker #(
  parameter int unsigned TIMEOUT = 150,
  localparam int unsigned IW = $clog2(TIMEOUT + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic speed_100,
  input logic pulse_valid,
  input logic manch_present,
  input logic qual_o,
  input logic thresh_low_o,
  input logic adapt_run_o,
  input logic ref_rx_o,
  input logic speed_chg,
  input logic tmr_expire
);

  // Independent count of pulse-free cycles spent qualified at 100 Mb/s.
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      idle_cnt <= '0;
    else if (!qual_o || pulse_valid || !speed_100 || speed_chg)
      idle_cnt <= '0;
    else if (idle_cnt != IW'(TIMEOUT))
      idle_cnt <= idle_cnt + IW'(1);
  end

  AST_THRESH_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_low_o == qual_o); // R2

  AST_ADAPT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    adapt_run_o == qual_o); // R3

  AST_REF_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rx_o == qual_o); // R6

  AST_RISE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_o) |-> $past(pulse_valid)); // R1

  AST_IDLE_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o && speed_100 && !speed_chg) |->
      (tmr_expire == (!pulse_valid && idle_cnt == IW'(TIMEOUT - 1)))); // R4

  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o && speed_100 && !speed_chg && pulse_valid) |=> qual_o); // R4

  AST_MANCH_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o && !speed_100 && !manch_present) |=> !qual_o); // R5

  AST_SPEED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    speed_chg |=> !qual_o); // R9

endmodule

bind line_qualifier line_qualifier_checker #(
  .TIMEOUT(TIMEOUT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .speed_100     (speed_100),
  .pulse_valid   (pulse_valid),
  .manch_present (manch_present),
  .qual_o        (qual_o),
  .thresh_low_o  (thresh_low_o),
  .adapt_run_o   (adapt_run_o),
  .ref_rx_o      (ref_rx_o),
  .speed_chg     (speed_chg),
  .tmr_expire    (tmr_expire)
);

// File: tb/line_qualifier_test.sv
module line_qualifier_test;

  localparam int NEED = 2;
  localparam int TO   = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_100 = 1'b1;
  logic pulse_valid = 1'b0;
  logic manch_present = 1'b0;
  logic qual_o, thresh_low_o, adapt_run_o, ref_rx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side expectation state.
  bit m_pass = 1'b0;
  int m_n = 0;
  int m_age = 0;
  int m_idle = 0;
  bit m_prev = 1'b1;

  always #4 clk = ~clk;

  line_qualifier #(.NEED_PULSES(NEED), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100),
    .pulse_valid(pulse_valid), .manch_present(manch_present),
    .qual_o(qual_o), .thresh_low_o(thresh_low_o),
    .adapt_run_o(adapt_run_o), .ref_rx_o(ref_rx_o)
  );

  function automatic bit one_bit(input bit v);
    return v;
  endfunction

  task automatic cmp(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req,  "qual_o",       qual_o,       m_pass);
    cmp("R2", "thresh_low_o", thresh_low_o, one_bit(m_pass));
    cmp("R3", "adapt_run_o",  adapt_run_o,  one_bit(m_pass));
    cmp("R6", "ref_rx_o",     ref_rx_o,     one_bit(m_pass));
  endtask

  task automatic expect_pass(input string req, input bit exp);
    cmp(req, "qual_o directed", qual_o, exp);
  endtask

  task automatic model_update(input bit p, input bit m, input bit s);
    if (s != m_prev) begin
      m_pass = 1'b0;
      m_n = 0;
    end else if (!m_pass) begin
      if (p) begin
        m_n++;
        m_age = 0;
        if (m_n >= NEED) begin
          m_pass = 1'b1;
          m_n = 0;
          m_idle = 0;
        end
      end else if (m_n > 0) begin
        m_age++;
        if (m_age >= TO) m_n = 0;
      end
    end else if (s) begin
      if (p) m_idle = 0;
      else begin
        m_idle++;
        if (m_idle >= TO) m_pass = 1'b0;
      end
    end else if (!m) begin
      m_pass = 1'b0;
    end
    m_prev = s;
  endtask

  task automatic step(input bit p, input bit m, input bit s, input string req);
    pulse_valid = p;
    manch_present = m;
    speed_100 = s;
    @(posedge clk);
    model_update(p, m, s);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset holds every output low even with activity on the inputs.
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      pulse_valid = 1'b1;
      manch_present = 1'b1;
      @(negedge clk);
      check_all("R7");
    end
    pulse_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R7");

    // R8: isolated pulse ages out; a later lone pulse does not qualify.
    step(1, 1, 1, "R8");
    for (int i = 0; i < TO + 3; i++) step(0, 1, 1, "R8");
    step(1, 1, 1, "R8");
    expect_pass("R8", 1'b0);
    // R1: second pulse exactly TO cycles after the first still qualifies.
    for (int i = 0; i < TO - 1; i++) step(0, 1, 1, "R8");
    step(1, 1, 1, "R1");
    expect_pass("R1", 1'b1);

    // R4: idle timeout boundary.
    for (int i = 0; i < TO - 1; i++) step(0, 1, 1, "R4");
    expect_pass("R4", 1'b1);
    step(0, 1, 1, "R4");
    expect_pass("R4", 1'b0);

    // R4: pulses reload the idle count.
    step(1, 1, 1, "R1");
    step(1, 1, 1, "R1");
    expect_pass("R1", 1'b1);
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < TO - 10; i++) step(0, 1, 1, "R4");
      step(1, 1, 1, "R4");
      expect_pass("R4", 1'b1);
    end
    for (int i = 0; i < TO + 2; i++) step(0, 1, 1, "R4");
    expect_pass("R4", 1'b0);

    // R8: gap of TO+1 cycles does not qualify.
    step(1, 1, 1, "R8");
    for (int i = 0; i < TO; i++) step(0, 1, 1, "R8");
    step(1, 1, 1, "R8");
    expect_pass("R8", 1'b0);
    for (int i = 0; i < TO + 2; i++) step(0, 1, 1, "R8");

    // R5: 10 Mb/s mode ignores idle gaps, drops on Manchester loss.
    step(0, 1, 0, "R9");
    step(1, 1, 0, "R5");
    step(1, 1, 0, "R5");
    expect_pass("R5", 1'b1);
    for (int i = 0; i < 400; i++) step(0, 1, 0, "R5");
    expect_pass("R5", 1'b1);
    step(0, 0, 0, "R5");
    expect_pass("R5", 1'b0);

    // R9: speed change drops the flag and clears a partial count.
    step(1, 1, 0, "R9");
    step(1, 1, 0, "R9");
    expect_pass("R9", 1'b1);
    step(0, 1, 1, "R9");
    expect_pass("R9", 1'b0);
    step(1, 1, 1, "R9");
    step(0, 1, 0, "R9");
    step(1, 1, 0, "R9");
    expect_pass("R9", 1'b0);
    step(1, 1, 0, "R9");
    expect_pass("R9", 1'b1);

    // Constrained random traffic against the bench model.
    begin
      int seed_dummy;
      int density;
      bit sp;
      seed_dummy = $urandom(32'h1A2B3C4D);
      sp = 1'b1;
      density = 4;
      for (int c = 0; c < 40000; c++) begin
        bit p, m;
        if (c % 500 == 0) begin
          case ($urandom_range(0, 3))
            0: density = 3;
            1: density = 60;
            2: density = 160;
            default: density = 0;
          endcase
        end
        if ($urandom_range(0, 2999) == 0) sp = ~sp;
        p = (density != 0) && ($urandom_range(0, density - 1) == 0);
        m = ($urandom_range(0, 299) != 0);
        step(p, m, sp, sp ? "R4" : "R5");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule